// File: doc/BRIEF.md
# Beam Sync Source Selector

This block produces the accelerator beam-sync pulse and the sync pulse sent to an external programmable timer. It has two local sources. The first is the AC line-sync, which is synchronized into the clock domain, edge-detected and divided down to a sub-harmonic of 60 Hz. The second is an off-line sync in the 57 to 60 Hz range, made by dividing the board clock. The divided line pulse is always presented on `harm_sync_o`, because it is also the start reference for the external timer.

Two source-select bits build a two-level mux. The low bit picks the local sync: the divided line or the off-line sync. The high bit picks the local sync or the external timer's sync as the beam-sync. Every output is a registered one-clock pulse. A new harmonic or off-line frequency selection is only adopted at the end of the period that is running, so no shortened period appears. The status byte `readback_o` returns the two select bits swapped into its top positions, and it also returns the divider selections now in force.

Top module: `beam_sync_selector`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `harm_sync_o` and `beam_sync_o` are 0 and `readback_o` is 8'h00. Both divider selections start at 2'b00.
- R2: Each rising edge of `line_sync_in` is counted exactly once, however many clock cycles the input stays high. The edge is found after a synchronizer of `SYNC_STAGES` flops.
- R3: `harm_sync_o` gives a one-clock pulse on every Nth counted line edge. N is 1, 2, 4 or 6 for a harmonic selection of 2'b00, 2'b01, 2'b10 or 2'b11. Counting starts from zero after reset.
- R4: A change on `harm_sel_i` is adopted only on the line edge that produces a `harm_sync_o` pulse. `readback_o[1:0]` shows the selection in force.
- R5: The off-line sync pulses once every round(`CLK_HZ`/f) clock cycles, each pulse one clock wide. f is 60, 59, 58 or 57 for `offl_sel_i` = 2'b00, 2'b01, 2'b10 or 2'b11.
- R6: A change on `offl_sel_i` is adopted only at the end of the off-line period that is running. That period keeps its old length. `readback_o[3:2]` shows the selection in force.
- R7: With `src_sel_i[1]`=0, `beam_sync_o` follows the divided line pulse when `src_sel_i[0]`=0 and the off-line pulse when `src_sel_i[0]`=1. Pulses from the source not selected never appear.
- R8: With `src_sel_i[1]`=1, `beam_sync_o` follows `ext_sync_i` one clock later, and both local sources are ignored.
- R9: One cycle after `src_sel_i` is applied, `readback_o[7]` equals `src_sel_i[0]` and `readback_o[6]` equals `src_sel_i[1]`. `readback_o[5:4]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sync_in | input | 1 | AC line-sync level, asynchronous |
| ext_sync_i | input | 1 | One-clock sync pulse from the external programmable timer |
| harm_sel_i | input | 2 | Line sub-harmonic selection |
| offl_sel_i | input | 2 | Off-line frequency selection |
| src_sel_i | input | 2 | Bit 0: line or off-line local sync; bit 1: local or external |
| beam_sync_o | output | 1 | Selected beam-sync pulse |
| harm_sync_o | output | 1 | Divided line-sync pulse, also sent to the external timer |
| readback_o | output | 8 | Status: {sel[0], sel[1], 2'b00, off-line sel in force, harmonic sel in force} |

## Verification
The bench goes after the hand-over of a divider selection in the middle of a period. If the selection were taken at once, the period spanning the change would have the new length and the harmonic pulse count would drift from the edge-by-edge model. Long high levels on the line input check that one edge is counted once; a level-sensitive detector would count several times. The bench also checks that the select bits come back swapped in the top status bits and that each source not selected stays silent. A mux with swapped bits would let off-line or line pulses leak into windows where only the external or the line source should appear.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef logic [1:0] sel2_t;

  // Line sub-harmonic ratio: how many line edges make one output pulse
  function automatic int unsigned harm_ratio(input sel2_t s);
    case (s)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 6;
    endcase
  endfunction

  // Off-line divisor: round(clk_hz / f), f = 60 - s
  function automatic int unsigned offl_div(input int unsigned clk_hz, input sel2_t s);
    int unsigned f;
    f = 60 - int'(s);
    return (clk_hz + f / 2) / f;
  endfunction

endpackage

// File: rtl/bss_line_sync.sv
module bss_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R2

endmodule

// File: rtl/bss_line_divider.sv
module bss_line_divider
  import bss_pkg::*;
#(
  parameter int unsigned MAX_RATIO = 6
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  rise_i,
  input  sel2_t sel_i,
  output logic  pulse_o,
  output sel2_t app_o
);
  localparam int unsigned CW = $clog2(MAX_RATIO);

  logic [CW-1:0] term_tbl [4];
  logic [CW-1:0] cnt_q;
  logic          pulse_q;
  sel2_t         app_q;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_term
      assign term_tbl[g] = CW'(harm_ratio(sel2_t'(g)) - 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      app_q   <= 2'b00;
    end else begin
      pulse_q <= 1'b0;
      if (rise_i) begin
        if (cnt_q == term_tbl[app_q]) begin
          cnt_q   <= '0;
          pulse_q <= 1'b1;
          app_q   <= sel_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pulse_o = pulse_q;
  assign app_o   = app_q;

  AST_PULSE_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(rise_i)); // R3
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= term_tbl[app_q]); // R3
  AST_HSEL_AT_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    !$stable(app_q) |-> pulse_q); // R4

endmodule

// File: rtl/bss_offline_gen.sv
module bss_offline_gen
  import bss_pkg::*;
#(
  parameter int unsigned CLK_HZ = 8_000_000
) (
  input  logic  clk,
  input  logic  rst,
  input  sel2_t sel_i,
  output logic  pulse_o,
  output sel2_t app_o
);
  localparam int unsigned MAX_DIV = offl_div(CLK_HZ, 2'b11);
  localparam int unsigned CW      = $clog2(MAX_DIV);

  logic [CW-1:0] term_tbl [4];
  logic [CW-1:0] cnt_q;
  logic          pulse_q;
  sel2_t         app_q;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_term
      assign term_tbl[g] = CW'(offl_div(CLK_HZ, sel2_t'(g)) - 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      app_q   <= 2'b00;
    end else if (cnt_q == term_tbl[app_q]) begin
      cnt_q   <= '0;
      pulse_q <= 1'b1;
      app_q   <= sel_i;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;
  assign app_o   = app_q;

  AST_OFFL_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R5
  AST_OSEL_AT_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    !$stable(app_q) |-> pulse_q); // R6

endmodule

// File: rtl/bss_src_mux.sv
module bss_src_mux
  import bss_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  sel2_t sel_i,
  input  logic  line_i,
  input  logic  offl_i,
  input  logic  ext_i,
  output logic  beam_o
);
  logic local_sync;
  logic beam_q;

  assign local_sync = sel_i[0] ? offl_i : line_i;

  always_ff @(posedge clk) begin
    if (rst) beam_q <= 1'b0;
    else     beam_q <= sel_i[1] ? ext_i : local_sync;
  end

  assign beam_o = beam_q;

  AST_EXT_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (beam_q && $past(sel_i[1])) |-> $past(ext_i)); // R8
  AST_LINE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (beam_q && $past(sel_i == 2'b00)) |-> $past(line_i)); // R7
  AST_OFFL_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (beam_q && $past(sel_i == 2'b01)) |-> $past(offl_i)); // R7

endmodule

// File: rtl/beam_sync_selector.sv
module beam_sync_selector
  import bss_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 8_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_RATIO   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_sync_in,
  input  logic       ext_sync_i,
  input  logic [1:0] harm_sel_i,
  input  logic [1:0] offl_sel_i,
  input  logic [1:0] src_sel_i,
  output logic       beam_sync_o,
  output logic       harm_sync_o,
  output logic [7:0] readback_o
);
  logic  line_rise;
  logic  harm_pulse;
  logic  offl_pulse;
  sel2_t harm_app;
  sel2_t offl_app;
  sel2_t src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= 2'b00;
    else     src_q <= src_sel_i;
  end

  bss_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (line_sync_in),
    .rise_o  (line_rise)
  );

  bss_line_divider #(.MAX_RATIO(MAX_RATIO)) u_harm (
    .clk     (clk),
    .rst     (rst),
    .rise_i  (line_rise),
    .sel_i   (harm_sel_i),
    .pulse_o (harm_pulse),
    .app_o   (harm_app)
  );

  bss_offline_gen #(.CLK_HZ(CLK_HZ)) u_offl (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (offl_sel_i),
    .pulse_o (offl_pulse),
    .app_o   (offl_app)
  );

  bss_src_mux u_mux (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (src_q),
    .line_i (harm_pulse),
    .offl_i (offl_pulse),
    .ext_i  (ext_sync_i),
    .beam_o (beam_sync_o)
  );

  assign harm_sync_o = harm_pulse;
  // select bits come back swapped in the top two positions
  assign readback_o  = {src_q[0], src_q[1], 2'b00, offl_app, harm_app};

  AST_READBACK_SWAP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (readback_o[7] == $past(src_sel_i[0]) &&
                     readback_o[6] == $past(src_sel_i[1]))); // R9
  AST_READBACK_SPARE: assert property (@(posedge clk) disable iff (rst)
    readback_o[5:4] == 2'b00); // R9

endmodule

// File: tb/beam_sync_selector_tb_top.sv
`timescale 1ns/1ps
module beam_sync_selector_tb_top;
  localparam int unsigned BCLK = 6000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_sync_in = 1'b0;
  logic       ext_sync_i = 1'b0;
  logic [1:0] harm_sel_i = 2'b00;
  logic [1:0] offl_sel_i = 2'b00;
  logic [1:0] src_sel_i = 2'b00;
  logic       beam_sync_o;
  logic       harm_sync_o;
  logic [7:0] readback_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int h_cnt = 0;
  int b_cnt = 0;
  int b_last = -1;
  int b_iv = 0;
  // edge-by-edge reference for the line divider
  int mcnt = 0;
  int mexp = 0;
  logic [1:0] msel = 2'b00;

  always #4 clk = ~clk;

  beam_sync_selector #(.CLK_HZ(BCLK)) dut_i (
    .clk(clk), .rst(rst), .line_sync_in(line_sync_in), .ext_sync_i(ext_sync_i),
    .harm_sel_i(harm_sel_i), .offl_sel_i(offl_sel_i), .src_sel_i(src_sel_i),
    .beam_sync_o(beam_sync_o), .harm_sync_o(harm_sync_o), .readback_o(readback_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (harm_sync_o) h_cnt <= h_cnt + 1;
    if (beam_sync_o) begin
      b_cnt <= b_cnt + 1;
      if (b_last >= 0) b_iv <= cyc - b_last;
      b_last <= cyc;
    end
  end

  function automatic int exp_ratio(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int exp_odiv(input logic [1:0] s);
    int f;
    f = 60 - int'(s);
    return (int'(BCLK) + f / 2) / f;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_edge(input int hi);
    line_sync_in = 1'b1;
    tick(hi);
    line_sync_in = 1'b0;
    tick(4);
    if (mcnt == exp_ratio(msel) - 1) begin
      mcnt = 0;
      mexp++;
      msel = harm_sel_i;
    end else begin
      mcnt++;
    end
  endtask

  task automatic wait_beam();
    int start;
    start = b_cnt;
    while (b_cnt == start) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int sb, sh;
    logic [1:0] oapp, ns;
    void'($urandom(32'd1234));
    tick(3);
    check(beam_sync_o == 1'b0, "R1 beam in reset", beam_sync_o, 0);
    check(harm_sync_o == 1'b0, "R1 harm in reset", harm_sync_o, 0);
    check(readback_o == 8'h00, "R1 readback in reset", readback_o, 0);
    rst = 1'b0;
    tick(1);
    check(readback_o == 8'h00, "R1 readback after reset", readback_o, 0);
    check(harm_sync_o == 1'b0, "R1 harm after reset", harm_sync_o, 0);

    // R2/R3/R4: random harmonic selections and edge bursts, long and short highs
    for (int it = 0; it < 30; it++) begin
      harm_sel_i = 2'($urandom_range(0, 3));
      for (int e = 0; e < int'($urandom_range(1, 12)); e++)
        line_edge((it % 3 == 0) ? 20 : 3);
      tick(4);
      check(h_cnt == mexp, "R3 harmonic pulse count", h_cnt, mexp);
      check(readback_o[1:0] == msel, "R4 harmonic sel in force", readback_o[1:0], msel);
    end
    // R2: a single very long high counts once
    harm_sel_i = 2'b00;
    for (int e = 0; e < 6 && msel != 2'b00; e++) line_edge(3);
    sh = h_cnt;
    line_edge(60);
    tick(4);
    check(h_cnt - sh == 1, "R2 one count per long high", h_cnt - sh, 1);

    // R7 line path: ten line pulses, off-line pulses must not leak
    src_sel_i = 2'b00;
    tick(3);
    sb = b_cnt; sh = h_cnt;
    for (int e = 0; e < 10; e++) line_edge(3);
    tick(4);
    check(h_cnt - sh == 10, "R7 harmonic pulses at ratio 1", h_cnt - sh, 10);
    check(b_cnt - sb == 10, "R7 beam follows line only", b_cnt - sb, 10);

    // R8 external path
    src_sel_i = 2'b10;
    tick(3);
    ext_sync_i = 1'b1;
    tick(1);
    ext_sync_i = 1'b0;
    check(beam_sync_o == 1'b1, "R8 ext latency one clock", beam_sync_o, 1);
    tick(1);
    check(beam_sync_o == 1'b0, "R8 ext pulse one clock", beam_sync_o, 0);
    sb = b_cnt;
    for (int k = 0; k < 3; k++) begin
      line_edge(3);
      ext_sync_i = 1'b1;
      tick(1);
      ext_sync_i = 1'b0;
      tick(30);
    end
    tick(3);
    check(b_cnt - sb == 3, "R8 only ext pulses reach beam", b_cnt - sb, 3);

    // R9 readback of select bits, swapped
    for (int v = 0; v < 4; v++) begin
      src_sel_i = 2'(v);
      tick(1);
      check(readback_o[7] == src_sel_i[0], "R9 readback bit7", readback_o[7], src_sel_i[0]);
      check(readback_o[6] == src_sel_i[1], "R9 readback bit6", readback_o[6], src_sel_i[1]);
      check(readback_o[5:4] == 2'b00, "R9 readback spare", readback_o[5:4], 0);
    end

    // R5/R6/R7 off-line path
    src_sel_i = 2'b01;
    oapp = 2'b00;
    wait_beam();
    wait_beam();
    tick(1);
    check(b_iv == exp_odiv(oapp), "R5 R7 off-line period", b_iv, exp_odiv(oapp));
    for (int it = 0; it < 5; it++) begin
      ns = (it == 0) ? 2'b11 : 2'($urandom_range(0, 3));
      tick(10);
      offl_sel_i = ns;
      wait_beam();
      tick(1);
      check(b_iv == exp_odiv(oapp), "R6 running period keeps old length", b_iv, exp_odiv(oapp));
      check(readback_o[3:2] == ns, "R6 off-line sel in force", readback_o[3:2], ns);
      wait_beam();
      tick(1);
      check(b_iv == exp_odiv(ns), "R5 off-line period", b_iv, exp_odiv(ns));
      oapp = ns;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule